// File: doc/BRIEF.md
# Nine-Bit Three-Wire Command Serializer

This block turns a byte stream into command packets for a display controller that listens on a three-wire serial link: chip select, clock and one data line. The link has no separate pin that says whether a byte is a command or a parameter. Instead, each byte is widened to a 9-bit word, and the extra bit carries that type. The type is set by where the byte sits in its packet. The first byte after a packet boundary is the command, and every byte after it is a parameter.

Upstream logic offers bytes with a valid/ready handshake and marks the final byte of each packet with a last flag. The serializer frames each word with its own chip-select pulse. It drives the clock in mode 3, so the clock rests high and the receiver samples data on the rising edge. It separates words with an idle gap. The serial rate comes from a divider input: each clock half-period lasts `clk_div + 1` system clocks, and the divider value is captured when a word is accepted. A busy output covers a whole packet, from its first accepted byte until chip select is released after its final word.

Top module: `tw9_cmd_tx`

## Requirements
- R1: Each byte becomes a 9-bit word in which the byte occupies bits 7..0 and bit 8 is the type flag. Words are sent MSB first, so the flag is the first bit on the wire and the byte follows from bit 7 down to bit 0.
- R2: The flag bit is 0 for the first byte of a packet (the command) and 1 for every later byte of the same packet (parameters).
- R3: A packet may consist of a single byte, which is sent as one command word with flag 0. The byte accepted after any byte marked last is always treated as a command.
- R4: The clock rests high whenever chip select is high. While chip select is low, the data line changes only while the clock is low or on its falling edge, never while the clock stays high.
- R5: Chip select goes low while the clock is high, before the first rising edge. Exactly 9 rising clock edges occur while it is low, and it rises only after the ninth bit.
- R6: Every clock low phase lasts `clk_div + 1` system clocks, using the divider value captured when the word was accepted. A later change of `clk_div` does not affect a word already in flight.
- R7: Chip select stays high for at least one bit period (`2*(clk_div+1)` system clocks) between consecutive words.
- R8: `in_ready` is high only while no word is being framed, so it is low whenever chip select is low and during the idle gap. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high, and valid bytes offered while ready is low produce no word.
- R9: `busy` is high from the cycle after the first byte of a packet is accepted until chip select is released after that packet's final word. It stays high between words of the packet, and it is low otherwise.
- R10: After reset, chip select and the clock are high, `in_ready` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIV_W | Half-period of the serial clock, minus one, in system clocks |
| in_data | input | 8 | Byte offered by the upstream source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte ends the current packet |
| in_ready | output | 1 | The serializer can take a byte this cycle |
| busy | output | 1 | A packet is in progress |
| spi_csn | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 3 (rests high) |
| spi_mosi | output | 1 | Serial data, MSB (flag) first |

## Verification
The stimulus covers several packet shapes:
- A command with parameters shows whether the flag switches from 0 to 1 after the first byte.
- Back-to-back single-byte packets show whether the last marker rearms command framing.
- Random packets of one to five bytes at random divider settings show any dependence of the framing or the bit order on the data or the rate.

Two directed cases probe the edges of the handshake and the divider. In one, a divider change in the middle of a word must leave that word's clock width unchanged. In the other, bytes offered with valid low must produce no frame. Monitors measure the clock low width, the inter-word gap and the busy flag against their expected values on every cycle.

// File: rtl/tw9_pkg.sv
// Package: shared constants, phase encoding and word packing for the
// nine-bit three-wire command serializer.
// Assumes 8-bit bytes; the word width is derived from the byte width.
package tw9_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = BYTE_W + 1;
    localparam int BIT_CNT_W  = $clog2(WORD_W);
    localparam int GAP_HALVES = 2;
    localparam int GAP_CNT_W  = $clog2(GAP_HALVES);

    // Phases of one framed word on the wire
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_LOW   = 3'd2,
        PH_HIGH  = 3'd3,
        PH_HOLD  = 3'd4,
        PH_GAP   = 3'd5
    } tx_phase_e;

    // Place the type flag above the byte so it leaves the shifter first
    function automatic logic [WORD_W-1:0] pack_word(input logic is_param,
                                                    input logic [BYTE_W-1:0] b);
        return {is_param, b};
    endfunction
endpackage

// File: rtl/tw9_half_timer.sv
// Module: tw9_half_timer
// Produces a one-cycle tick every (div+1) system clocks while run is high.
// Assumes: the divider is captured while run is low, so a word in flight
// keeps the rate it started with; the count restarts whenever run drops.
module tw9_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Capture the divider when idle; count half-period cycles when running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (!run) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (cnt_q == div_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div_q);
endmodule

// File: rtl/tw9_framer.sv
// Module: tw9_framer
// Tracks the packet boundary and builds the 9-bit word for each accepted
// byte: flag 0 for the first byte after a boundary, 1 for the rest.
// Assumes: accept happens only when valid and ready are both high.
module tw9_framer
    import tw9_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              ready_in,
    output logic              accept,
    output logic [WORD_W-1:0] word,
    output logic              pkt_open
);
    logic first_q;

    assign accept = in_valid && ready_in;

    // Remember whether the next accepted byte starts a new packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else if (accept) begin
            first_q <= in_last;
        end
    end

    assign word     = pack_word(!first_q, in_data);
    assign pkt_open = !first_q;
endmodule

// File: rtl/tw9_shifter.sv
// Module: tw9_shifter
// Frames one word on the wire: selects the receiver, shifts the word out
// MSB first with a mode-3 clock, holds, releases select and waits a gap.
// Assumes: tick marks the end of each half-period; load only in idle.
module tw9_shifter
    import tw9_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              tick,
    output logic              run,
    output logic              ready,
    output logic              csn,
    output logic              sck,
    output logic              mosi
);
    tx_phase_e            phase_q;
    logic [WORD_W-1:0]    sh_q;
    logic [BIT_CNT_W-1:0] bit_q;
    logic [GAP_CNT_W-1:0] gap_q;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);
    localparam logic [GAP_CNT_W-1:0] LAST_GAP = GAP_CNT_W'(GAP_HALVES - 1);

    // Phase sequencing, shift register and bit/gap counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sh_q    <= '0;
            bit_q   <= '0;
            gap_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (load) begin
                        sh_q    <= word;
                        bit_q   <= '0;
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: if (tick) phase_q <= PH_LOW;
                PH_LOW:   if (tick) phase_q <= PH_HIGH;
                PH_HIGH: begin
                    if (tick) begin
                        if (bit_q == LAST_BIT) begin
                            phase_q <= PH_HOLD;
                        end else begin
                            sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
                            bit_q   <= bit_q + 1'b1;
                            phase_q <= PH_LOW;
                        end
                    end
                end
                PH_HOLD: begin
                    if (tick) begin
                        gap_q   <= '0;
                        phase_q <= PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (tick) begin
                        if (gap_q == LAST_GAP) phase_q <= PH_IDLE;
                        else                   gap_q   <= gap_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the current phase
    always_comb begin
        run   = (phase_q != PH_IDLE);
        ready = (phase_q == PH_IDLE);
        csn   = !((phase_q == PH_SETUP) || (phase_q == PH_LOW) ||
                  (phase_q == PH_HIGH)  || (phase_q == PH_HOLD));
        sck   = (phase_q != PH_LOW);
        mosi  = sh_q[WORD_W-1];
    end
endmodule

// File: rtl/tw9_cmd_tx.sv
// Module: tw9_cmd_tx (top)
// Nine-bit three-wire command serializer: accepts bytes with valid/ready,
// tags each with a command/parameter flag from its packet position and
// sends it as a 9-bit mode-3 serial word under its own chip select.
// Assumes: clk_div is sampled when a word is accepted.
module tw9_cmd_tx
    import tw9_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              busy,
    output logic              spi_csn,
    output logic              spi_sck,
    output logic              spi_mosi
);
    logic              accept;
    logic [WORD_W-1:0] word;
    logic              pkt_open;
    logic              run;
    logic              tick;

    tw9_framer i_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .ready_in (in_ready),
        .accept   (accept),
        .word     (word),
        .pkt_open (pkt_open)
    );

    tw9_half_timer #(.DIV_W(DIV_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_in (clk_div),
        .tick   (tick)
    );

    tw9_shifter i_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .word  (word),
        .tick  (tick),
        .run   (run),
        .ready (in_ready),
        .csn   (spi_csn),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

    // Packet in progress: open packet, or a word still selected on the wire
    assign busy = pkt_open || !spi_csn;
endmodule

// File: rtl/tw9_cmd_tx_chk.sv
// Module: tw9_cmd_tx_chk
// Protocol checker bound to tw9_cmd_tx: mode-3 pin rules, nine clock
// edges per select pulse, handshake and busy relations, reset state.
module tw9_cmd_tx_chk
    import tw9_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic busy,
    input logic spi_csn,
    input logic spi_sck,
    input logic spi_mosi
);
    logic                 sck_q;
    logic [BIT_CNT_W:0]   edge_cnt;

    // Count rising clock edges inside the current select pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b1;
            edge_cnt <= '0;
        end else begin
            sck_q <= spi_sck;
            if (spi_csn)               edge_cnt <= '0;
            else if (spi_sck && !sck_q) edge_cnt <= edge_cnt + 1'b1;
        end
    end

    a_r4_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> spi_sck);

    a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck) && !spi_csn && !$past(spi_csn)) |-> $stable(spi_mosi));

    a_r5_select_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> (spi_sck && edge_cnt == '0));

    a_r5_nine_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_csn) |-> (edge_cnt == (BIT_CNT_W+1)'(WORD_W)));

    a_r8_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> spi_csn);

    a_r9_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(spi_csn));

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (spi_csn && spi_sck && in_ready && !busy));
endmodule

bind tw9_cmd_tx tw9_cmd_tx_chk i_tw9_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .busy     (busy),
    .spi_csn  (spi_csn),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/test_tw9_cmd_tx.sv
// Bench for tw9_cmd_tx: directed corner packets plus seeded random packets,
// words captured at the pins and compared with bench-computed words.
module test_tw9_cmd_tx;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_last = 1'b0;
    logic             in_ready, busy, spi_csn, spi_sck, spi_mosi;

    int total = 0;
    int bad = 0;

    tw9_cmd_tx #(.DIV_W(DIV_W)) i_tw9_cmd_tx (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .busy(busy), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected and captured words
    logic [8:0] exp_q[$];
    logic [8:0] got_q[$];
    logic [8:0] cap = '0;
    int         nb = 0;
    bit         in_frm = 1'b0;

    always @(negedge spi_csn) begin
        cap = '0; nb = 0; in_frm = 1'b1;
    end
    always @(posedge spi_sck) if (!spi_csn) begin
        cap = {cap[7:0], spi_mosi}; nb++;
    end
    always @(posedge spi_csn) if (in_frm) begin
        in_frm = 1'b0;
        got_q.push_back(cap);
        check(nb == 9, "R5 rising edges per word", nb, 9);
    end

    // Cycle monitors: clock low width, gap length, busy and ready
    int cur_h = 1, gap_h = 1, lowc = 0, gapc = 0, busy_err = 0, rdy_err = 0;
    bit seen = 1'b0, tb_open = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (!spi_sck) lowc++;
        else if (lowc != 0) begin
            check(lowc == cur_h, "R6 clock low width", lowc, cur_h);
            lowc = 0;
        end
        if (spi_csn) begin
            if (gapc == 0) gap_h = cur_h;
            gapc++;
        end else begin
            if (seen && gapc != 0) check(gapc >= 2*gap_h, "R7 idle gap", gapc, 2*gap_h);
            gapc = 0; seen = 1'b1;
        end
        if (busy !== (tb_open || !spi_csn)) busy_err++;
        if (in_ready && !spi_csn) rdy_err++;
    end

    task automatic push_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        in_data = b; in_last = last; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({tb_open, b});
        @(posedge clk);
        tb_open = !last;
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R8 ready low after accept", int'(in_ready), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || !in_ready) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        check(got_q.size() == exp_q.size(), {tag, " word count"}, got_q.size(), exp_q.size());
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [8:0] g, e;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            check(g[8] == e[8], {tag, " R2 flag bit"}, int'(g[8]), int'(e[8]));
            check(g[7:0] == e[7:0], {tag, " R1 byte bits"}, int'(g[7:0]), int'(e[7:0]));
        end
        got_q.delete(); exp_q.delete();
    endtask

    task automatic send_pkt(input int n, input int div, input logic [7:0] base, input bit rnd);
        wait_idle();
        clk_div = DIV_W'(div); cur_h = div + 1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = rnd ? 8'($urandom) : base + 8'(i);
            push_byte(b, i == n-1);
        end
        wait_idle();
    endtask

    initial begin
        void'($urandom(32'h0000_5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(spi_csn == 1'b1, "R10 csn after reset", int'(spi_csn), 1);
        check(spi_sck == 1'b1, "R10 sck after reset", int'(spi_sck), 1);
        check(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
        check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);

        // R1 R2: command with parameters, fastest rate
        send_pkt(3, 0, 8'hA5, 1'b0);
        compare("R1 fast packet");

        // R3: single-byte packets back to back, then a new packet
        send_pkt(1, 1, 8'h3C, 1'b0);
        send_pkt(1, 1, 8'hC3, 1'b0);
        send_pkt(2, 2, 8'h80, 1'b0);
        compare("R3 single-byte packets");

        // R6: divider change during a word does not alter that word
        wait_idle();
        clk_div = 8'd4; cur_h = 5;
        push_byte(8'h5A, 1'b1);
        clk_div = 8'd9;
        wait_idle();
        compare("R6 divider latched");

        // R8: bytes offered with valid low are ignored
        wait_idle();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_data = 8'(i); in_last = i[0];
            check(spi_csn == 1'b1, "R8 no frame without valid", int'(spi_csn), 1);
        end
        check(got_q.size() == 0, "R8 no word without valid", got_q.size(), 0);

        // R7 R9: longer packet at a slower rate
        send_pkt(4, 5, 8'h10, 1'b0);
        compare("R9 slow packet");

        // Random packets
        for (int p = 0; p < 25; p++) begin
            send_pkt(1 + int'($urandom % 5), int'($urandom % 4), 8'h00, 1'b1);
            compare("R2 random packet");
        end

        check(busy_err == 0, "R9 busy tracking mismatches", busy_err, 0);
        check(rdy_err == 0, "R8 ready while selected", rdy_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule